// File: doc/BRIEF.md
# PHY Test-Port Request Bridge

This block sits in a per-PHY register window and turns one software write into one transaction on the PHY's internal test port. The test port reaches a configuration space of 8-bit locations with 12-bit addresses. Software packs an opcode, a target address and write data into a single request word. It then polls a completion register until the busy flag drops. For reads, it picks up the returned byte from a second field of that same register.

A mode register decides who owns the test port. With mode 0 the port belongs to the PHY's own power-up state machine, and the bridge ignores requests. With mode 1 the request register drives the port. Three opcodes are defined: read, write and a reset that clears the whole configuration space. Read and write take a fixed number of cycles, and reset takes a separately set number. The configuration space is modelled by an internal, parameter-sized bank of byte locations. This lets the bridge be exercised end to end.

Software never has to guess what happened to a request. A request written while the previous one is still running is dropped, and a sticky overrun flag records the loss. The fourth opcode value is reserved. It finishes at once and changes nothing.

Top module: `phy_test_bridge`

## Requirements
- R1: Registers sit at byte offsets 0x10 (mode), 0x14 (request) and 0x18 (completion) of the window. The request register and every other offset read as 0. In the request word, the opcode is bits [1:0], the address is bits [15:4] and the write data is bits [23:16].
- R2: Bit 0 of the mode register is stored and reads back. While it is 0, requests are ignored: busy stays 0, and neither the bank nor the read-data field changes.
- R3: Completion bit 0 is the busy flag. An accepted read or write raises it on the edge after the request write. It stays 1 for ACC_LAT cycles and then returns to 0.
- R4: Opcode 0 (read) places the byte at the target address in completion bits [15:8] when it finishes, and the data field of the request is ignored. That field changes only when a read finishes.
- R5: Opcode 1 (write) stores request bits [23:16] at the target address when it finishes.
- R6: Opcode 2 (reset) keeps busy at 1 for RST_LAT cycles and then clears every bank location to 0.
- R7: Opcode 3 is reserved. It never sets busy and changes no location and no field.
- R8: A request written while busy is 1 is dropped and sets completion bit 1. That bit stays set until software writes the completion register with bit 1 equal to 1.
- R9: Targets at or above DEPTH are out of range. Writes to them change nothing and reads of them return 0.
- R10: After hardware reset, mode, busy, overrun, the read-data field and every bank location are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_addr | input | 6 | Byte offset within the per-PHY window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A wrong busy counter shows on the completion register within one cycle: the busy bit drops early or late against the reference model, which is compared on every clock. A corrupted bank location or a missed clear does not appear until a later read of that address finishes. It then surfaces ACC_LAT cycles after that read is issued, as a wrong byte in bits [15:8]. Overrun and mode errors appear in the very cycle after the offending write, either as the sticky bit or as busy rising when it should not.

// File: rtl/phy_tb_pkg.sv
package phy_tb_pkg;
  localparam int WIN_AW  = 6;
  localparam int TADDR_W = 12;
  localparam int TDATA_W = 8;

  localparam logic [WIN_AW-1:0] OFS_MODE = 6'h10;
  localparam logic [WIN_AW-1:0] OFS_REQ  = 6'h14;
  localparam logic [WIN_AW-1:0] OFS_CMPL = 6'h18;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RST = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  typedef struct packed {
    logic [TDATA_W-1:0] data;
    logic [TADDR_W-1:0] addr;
    logic [1:0]         pad;
    op_e                op;
  } req_t;
endpackage

// File: rtl/phy_tb_csr.sv
module phy_tb_csr
  import phy_tb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WIN_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy_i,
  input  logic [TDATA_W-1:0] rd_data_i,
  output logic              mode_o,
  output logic              fire_o,
  output req_t              req_o,
  output logic              ovr_o,
  output logic [31:0]       reg_rdata
);
  logic mode_q, mode_d, mode_en;
  logic ovr_q, ovr_d, ovr_en;
  logic hit_mode, hit_req, hit_cmpl;
  logic req_wr, clr_wr;
  logic unused_hi;

  assign req_o    = reg_wdata[23:0];
  assign unused_hi = ^reg_wdata[31:24];

  assign hit_mode = (reg_addr == OFS_MODE);
  assign hit_req  = (reg_addr == OFS_REQ);
  assign hit_cmpl = (reg_addr == OFS_CMPL);

  assign req_wr = reg_wr && hit_req && mode_q;
  assign clr_wr = reg_wr && hit_cmpl && reg_wdata[1];

  always_comb begin
    mode_en = reg_wr && hit_mode;
    mode_d  = reg_wdata[0];
    ovr_en  = (req_wr && busy_i) || clr_wr;
    ovr_d   = req_wr && busy_i;
    fire_o  = req_wr && !busy_i && (req_o.op != OP_RSV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (ovr_en)  ovr_q  <= ovr_d;
    end
  end

  assign mode_o = mode_q;
  assign ovr_o  = ovr_q;

  always_comb begin
    reg_rdata = '0;
    if (hit_mode) reg_rdata[0] = mode_q;
    if (hit_cmpl) reg_rdata = {16'h0, rd_data_i, 6'h0, ovr_q, busy_i};
  end
endmodule

// File: rtl/phy_tb_seq.sv
module phy_tb_seq
  import phy_tb_pkg::*;
#(
  parameter int ACC_LAT = 2,
  parameter int RST_LAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  req_t               req_i,
  output logic               busy_o,
  output logic               done_o,
  output op_e                op_o,
  output logic [TADDR_W-1:0] addr_o,
  output logic [TDATA_W-1:0] data_o
);
  localparam int MAXL = (ACC_LAT > RST_LAT) ? ACC_LAT : RST_LAT;
  localparam int CW   = (MAXL > 1) ? $clog2(MAXL) : 1;

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  req_t          req_q;
  logic          unused_pad;

  assign done_o     = busy_q && (cnt_q == '0);
  assign unused_pad = ^req_q.pad;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (fire_i) begin
      busy_d = 1'b1;
      cnt_en = 1'b1;
      cnt_d  = (req_i.op == OP_RST) ? CW'(RST_LAT - 1) : CW'(ACC_LAT - 1);
    end else if (busy_q) begin
      if (done_o) begin
        busy_d = 1'b0;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      req_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (fire_i) req_q <= req_i;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = req_q.op;
  assign addr_o = req_q.addr;
  assign data_o = req_q.data;
endmodule

// File: rtl/phy_tb_bank.sv
module phy_tb_bank
  import phy_tb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic                     clr_i,
  input  logic [TADDR_W-1:0]       addr_i,
  input  logic [TDATA_W-1:0]       wdata_i,
  output logic [TDATA_W-1:0]       rdata_o,
  output logic [DEPTH*TDATA_W-1:0] cells_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          in_range;
  logic [IW-1:0] idx;
  logic [TDATA_W-1:0] cell_arr [DEPTH];

  assign in_range = (32'(addr_i) < DEPTH);
  assign idx      = addr_i[IW-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [TDATA_W-1:0] cell_q, cell_d;
    logic               cell_en;

    always_comb begin
      cell_en = clr_i || (wr_i && in_range && (32'(idx) == g));
      cell_d  = clr_i ? '0 : wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_en) cell_q <= cell_d;
    end

    assign cell_arr[g] = cell_q;
    assign cells_o[g*TDATA_W +: TDATA_W] = cell_q;
  end

  assign rdata_o = in_range ? cell_arr[idx] : '0;
endmodule

// File: rtl/phy_test_bridge.sv
module phy_test_bridge
  import phy_tb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ACC_LAT = 2,
  parameter int RST_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WIN_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic               mode_q, fire, ovr_q, busy, done;
  req_t               req_w;
  op_e                op_q;
  logic [TADDR_W-1:0] addr_q;
  logic [TDATA_W-1:0] data_q, bank_rdata, rd_q;
  logic [DEPTH*TDATA_W-1:0] bank_flat;
  logic               rd_en, bank_wr, bank_clr;

  phy_tb_csr u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy_i(busy), .rd_data_i(rd_q),
    .mode_o(mode_q), .fire_o(fire), .req_o(req_w), .ovr_o(ovr_q),
    .reg_rdata(reg_rdata)
  );

  phy_tb_seq #(.ACC_LAT(ACC_LAT), .RST_LAT(RST_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .req_i(req_w),
    .busy_o(busy), .done_o(done), .op_o(op_q), .addr_o(addr_q),
    .data_o(data_q)
  );

  assign bank_wr  = done && (op_q == OP_WR);
  assign bank_clr = done && (op_q == OP_RST);
  assign rd_en    = done && (op_q == OP_RD);

  phy_tb_bank #(.DEPTH(DEPTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_i(bank_wr), .clr_i(bank_clr),
    .addr_i(addr_q), .wdata_i(data_q), .rdata_o(bank_rdata),
    .cells_o(bank_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= bank_rdata;
  end
endmodule

// File: rtl/phy_tb_bridge_chk.sv
module phy_tb_bridge_chk
  import phy_tb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [WIN_AW-1:0]        reg_addr,
  input logic [1:0]               wop,
  input logic                     wclr,
  input logic                     mode_q,
  input logic                     busy,
  input logic                     done,
  input logic [1:0]               op_q,
  input logic [TDATA_W-1:0]       rd_q,
  input logic                     ovr_q,
  input logic [DEPTH*TDATA_W-1:0] bank_flat
);
  // R3
  busy_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == OFS_REQ && mode_q));

  // R2
  mode_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !busy) |=> !busy);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(reg_wr && reg_addr == OFS_CMPL && wclr)) |=> ovr_q);

  // R7
  rsv_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_REQ && wop == 2'd3 && !busy) |=> !busy);

  // R6
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 2'd2) |=> (bank_flat == '0));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && op_q == 2'd0) |=> $stable(rd_q));
endmodule

bind phy_test_bridge phy_tb_bridge_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wop(reg_wdata[1:0]), .wclr(reg_wdata[1]), .mode_q(mode_q),
  .busy(busy), .done(done), .op_q(op_q), .rd_q(rd_q), .ovr_q(ovr_q),
  .bank_flat(bank_flat)
);

// File: tb/tb_phy_test_bridge.sv
module tb_phy_test_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int ACC = 2;
  localparam int RST = 4;
  localparam logic [5:0] A_MODE = 6'h10, A_REQ = 6'h14, A_CMPL = 6'h18;

  logic clk, rst_n, reg_wr;
  logic [5:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  phy_test_bridge #(.DEPTH(DEPTH), .ACC_LAT(ACC), .RST_LAT(RST)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_mode, m_busy, m_cnt, m_op, m_addr, m_data, m_ovr, m_rd;
  int m_bank [DEPTH];
  int ob, om, wop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_busy = 0; m_cnt = 0; m_op = 0; m_addr = 0;
      m_data = 0; m_ovr = 0; m_rd = 0;
      foreach (m_bank[i]) m_bank[i] = 0;
    end else begin
      ob = m_busy; om = m_mode;
      wop = int'(reg_wdata[1:0]);
      if (reg_wr && reg_addr == A_REQ && om == 1) begin
        if (ob == 1) m_ovr = 1;
        else if (wop != 3) begin
          m_busy = 1; m_op = wop;
          m_addr = int'(reg_wdata[15:4]); m_data = int'(reg_wdata[23:16]);
          m_cnt = ((wop == 2) ? RST : ACC) - 1;
        end
      end
      if (reg_wr && reg_addr == A_MODE) m_mode = int'(reg_wdata[0]);
      if (reg_wr && reg_addr == A_CMPL && reg_wdata[1]) m_ovr = 0;
      if (ob == 1) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_op == 0) m_rd = (m_addr < DEPTH) ? m_bank[m_addr] : 0;
          else if (m_op == 1) begin
            if (m_addr < DEPTH) m_bank[m_addr] = m_data;
          end else foreach (m_bank[i]) m_bank[i] = 0;
        end else m_cnt--;
      end
    end
  end

  function automatic logic [31:0] model_rd(logic [5:0] a);
    if (a == A_MODE) return 32'(m_mode);
    if (a == A_CMPL) return 32'((m_rd << 8) | (m_ovr << 1) | m_busy);
    return 32'h0;
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] e, d;
      string tag;
      e = model_rd(reg_addr);
      d = e ^ reg_rdata;
      n_tests++;
      if (d != 0) begin
        n_fail++;
        if (reg_addr == A_MODE) tag = "R2";
        else if (reg_addr != A_CMPL) tag = "R1";
        else if (d[0]) tag = "R3";
        else if (d[1]) tag = "R8";
        else tag = "R4";
        $display("FAIL %s model compare @%0t addr=%h actual=%h expected=%h",
                 tag, $time, reg_addr, reg_rdata, e);
      end
    end
  end

  function automatic logic [31:0] rq(int op, int a, int d);
    return {8'h0, d[7:0], a[11:0], 2'b00, op[1:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = A_CMPL; reg_wdata = '0;
  endtask

  task automatic peek(logic [5:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, e);
  endtask

  task automatic sample_busy(logic e, string tag);
    @(negedge clk);
    chk(tag, {31'h0, reg_rdata[0]}, {31'h0, e});
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = A_CMPL; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R10 reset state, R1 register map
    peek(A_MODE, 32'h0, "R10");
    peek(A_CMPL, 32'h0, "R10");
    peek(A_REQ, 32'h0, "R1");
    peek(6'h00, 32'h0, "R1");

    // R2 requests ignored in mode 0
    wr(A_REQ, rq(1, 2, 8'h33));
    sample_busy(1'b0, "R2");
    wr(A_MODE, 32'h1);
    peek(A_MODE, 32'h1, "R2");
    wr(A_REQ, rq(0, 2, 0));
    idle(4);
    peek(A_CMPL, 32'h0, "R2");

    // R3 busy duration for a write, R5 store
    wr(A_REQ, rq(1, 2, 8'hA5));
    for (int i = 0; i < ACC; i++) sample_busy(1'b1, "R3");
    sample_busy(1'b0, "R3");

    // R4 read with data field set (ignored)
    wr(A_REQ, rq(0, 2, 8'hFF));
    idle(4);
    peek(A_CMPL, 32'h0000A500, "R4");

    // R8 overrun
    wr(A_REQ, rq(1, 4, 8'h11));
    wr(A_REQ, rq(1, 5, 8'h22));
    idle(4);
    peek(A_CMPL, 32'h0000A502, "R8");
    wr(A_REQ, rq(0, 5, 0));
    idle(4);
    peek(A_CMPL, 32'h00000002, "R8");
    wr(A_REQ, rq(0, 4, 0));
    idle(4);
    peek(A_CMPL, 32'h00001102, "R5");
    wr(A_CMPL, 32'h2);
    peek(A_CMPL, 32'h00001100, "R8");

    // R7 reserved opcode
    wr(A_REQ, rq(3, 4, 8'h99));
    sample_busy(1'b0, "R7");
    idle(3);
    peek(A_CMPL, 32'h00001100, "R7");
    wr(A_REQ, rq(0, 4, 0));
    idle(4);
    peek(A_CMPL, 32'h00001100, "R7");

    // R9 out of range
    wr(A_REQ, rq(1, 12'h100, 8'h77));
    idle(4);
    wr(A_REQ, rq(0, 12'h100, 0));
    idle(4);
    peek(A_CMPL, 32'h0, "R9");
    wr(A_REQ, rq(1, DEPTH, 8'h66));
    idle(4);
    wr(A_REQ, rq(0, 0, 0));
    idle(4);
    peek(A_CMPL, 32'h0, "R9");

    // R6 reset opcode
    wr(A_REQ, rq(2, 0, 0));
    for (int i = 0; i < RST; i++) sample_busy(1'b1, "R6");
    sample_busy(1'b0, "R6");
    wr(A_REQ, rq(0, 4, 0));
    idle(4);
    peek(A_CMPL, 32'h0, "R6");
    wr(A_REQ, rq(0, 2, 0));
    idle(4);
    peek(A_CMPL, 32'h0, "R6");

    // R5 then R2 write ignored in mode 0
    wr(A_REQ, rq(1, 7, 8'h3C));
    idle(4);
    wr(A_REQ, rq(0, 7, 0));
    idle(4);
    peek(A_CMPL, 32'h00003C00, "R5");
    wr(A_MODE, 32'h0);
    wr(A_REQ, rq(1, 7, 8'h00));
    sample_busy(1'b0, "R2");
    wr(A_MODE, 32'h1);
    wr(A_REQ, rq(0, 7, 0));
    idle(4);
    peek(A_CMPL, 32'h00003C00, "R2");

    // mixed traffic, checked every clock against the model
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0)      wr(A_MODE, {31'h0, ($urandom_range(0, 5) != 0)});
      else if (sel == 1) wr(A_CMPL, {30'h0, 1'($urandom_range(0, 1)), 1'b0});
      else if (sel == 2) wr(6'h20, $urandom);
      else if (sel < 6)  idle(int'($urandom_range(1, 3)));
      else wr(A_REQ, rq(int'($urandom_range(0, 3)) & ((sel == 9) ? 3 : 1),
                        int'($urandom_range(0, DEPTH + 3)),
                        int'($urandom_range(0, 255))));
    end
    idle(8);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule